// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the privileged control state of a processor core as an indexed bank of 64-bit registers. It has one write port and one read port. Each index carries its own access rule. Some indices store the full word. Some keep only a defined set of bits. Some clear on any write. Some are read-only, some are write-only, and some are commands that store nothing and raise a one-cycle pulse. One index is a cycle counter: its low half is a live free-running count and its high half is written by software. Reads are combinational from the current state. Writes take effect at the clock edge. Illegal accesses latch a sticky error flag and leave the stored state untouched.

Two small state machines carry the control behaviour. The error tracker has two states. It sits in ERR_CLEAR and moves to ERR_HELD on the first edge at which an illegal read or write is presented. ERR_HELD is left only through reset. The counter-control guard also has two states. It sits in ONCE_OPEN and moves to ONCE_SPENT when the counter-control index is first written. In ONCE_SPENT any further write to that index is illegal. Invalidate commands for an external address-translation cache appear as combinational pulses in the same cycle as the command write.

Top module: `ctlreg_file`

## Requirements
- R1: After reset every defined index reads zero, with three exceptions. Index 8 (code base) reads parameter CODE_BASE_RST, whose default is 0x8000. Index 9 (miscellaneous control) reads 0x6. Index 7 (the last scratch register) reads cpu_id zero-extended. The error flag is 0 after reset.
- R2: Indices 0-9 store the full 64-bit write data. A write at a clock edge is visible on rd_data from that edge on.
- R3: Masked indices keep only their defined bits on write, and the other bits read zero: 11 and 12 keep mask 0xF, 13 keeps 0x1F, 14 keeps 0x18, 16 keeps 0x7FFF0, 17 keeps 0xFF_FFFF_0300, 18 keeps 0xFFFF_FFFF_C000_0000, 19 keeps 0x1FFB, 20 keeps 0x3F, 21 keeps 0x7F0, and 22 keeps 0xFE00_0000_0000_0000.
- R4: Index 10 (exception address) stores the write data with bit 1 forced to zero.
- R5: Any write to index 23 (exception summary) or index 24 (exception mask) clears that register to zero, whatever the data.
- R6: A write to a read-only index (25, 26) raises the error flag and leaves the register at its old value.
- R7: A read of a write-only index (15, 35) or of a command index (29-34) raises the error flag and returns rd_data zero.
- R8: A read or a write of an undefined index (36-63) raises the error flag. An undefined read returns zero.
- R9: The error flag rises at the clock edge at which the illegal access is presented and stays high until reset.
- R10: A read of index 27 (cycle counter) returns the stored bits 63:32 above a live count, in bits 31:0, of the clock edges since reset release. A write stores the upper half.
- R11: The first write to index 28 (counter control) makes it read 1. Any later write before reset raises the error flag.
- R12: Writes to command indices pulse one output in the same cycle. The outputs are 29 data-side all, 30 data-side per-process, 31 data-side one address, 32 instruction-side all, 33 instruction-side per-process and 34 instruction-side one address. At most one pulse is high. xlat_va equals wr_data during a one-address command and is zero otherwise.
- R13: When a read and a write to the same index share a cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_id | input | CPU_ID_W | Core number loaded into scratch index 7 at reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 6 | Read index |
| rd_data | output | 64 | Read data, zero when idle or illegal |
| err | output | 1 | Sticky illegal-access flag |
| xlat_d_all | output | 1 | Data-side invalidate-all pulse |
| xlat_d_asn | output | 1 | Data-side per-process invalidate pulse |
| xlat_d_one | output | 1 | Data-side single-address invalidate pulse |
| xlat_i_all | output | 1 | Instruction-side invalidate-all pulse |
| xlat_i_asn | output | 1 | Instruction-side per-process invalidate pulse |
| xlat_i_one | output | 1 | Instruction-side single-address invalidate pulse |
| xlat_va | output | 64 | Address for single-address invalidates |

## Verification
The assertions rely on reset being held for at least one clock edge before any access, so that the live count and both state machines start from known values. They also rely on wr_idx and wr_data being stable through each clock period. The bench drives all inputs on the falling edge and resets before each index in the sweep, so every index is seen in both its fresh and its written state. It samples combinational outputs a few nanoseconds after driving and checks registered state on the following falling edge.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int XLEN     = 64;
    localparam int IDX_W    = 6;
    localparam int NUM_DEF  = 36;

    typedef enum logic [3:0] {
        RULE_NONE,
        RULE_RW,
        RULE_MASK,
        RULE_W2C,
        RULE_RO,
        RULE_WO,
        RULE_CMD,
        RULE_CYC,
        RULE_ONCE
    } rule_e;

    typedef enum logic {ERR_CLEAR, ERR_HELD}    err_state_e;
    typedef enum logic {ONCE_OPEN, ONCE_SPENT}  once_state_e;

    typedef struct packed {
        logic d_all;
        logic d_asn;
        logic d_one;
        logic i_all;
        logic i_asn;
        logic i_one;
    } inv_t;

    localparam logic [IDX_W-1:0] IX_SCR_CPU   = 6'd7;
    localparam logic [IDX_W-1:0] IX_CODE_BASE = 6'd8;
    localparam logic [IDX_W-1:0] IX_MISC      = 6'd9;
    localparam logic [IDX_W-1:0] IX_EXC_ADDR  = 6'd10;
    localparam logic [IDX_W-1:0] IX_AST_REQ   = 6'd11;
    localparam logic [IDX_W-1:0] IX_AST_EN    = 6'd12;
    localparam logic [IDX_W-1:0] IX_IPL       = 6'd13;
    localparam logic [IDX_W-1:0] IX_CUR_MODE  = 6'd14;
    localparam logic [IDX_W-1:0] IX_ALT_MODE  = 6'd15;
    localparam logic [IDX_W-1:0] IX_SWI_REQ   = 6'd16;
    localparam logic [IDX_W-1:0] IX_ICTL      = 6'd17;
    localparam logic [IDX_W-1:0] IX_PT_BASE   = 6'd18;
    localparam logic [IDX_W-1:0] IX_CTEST     = 6'd19;
    localparam logic [IDX_W-1:0] IX_CMODE     = 6'd20;
    localparam logic [IDX_W-1:0] IX_IASN      = 6'd21;
    localparam logic [IDX_W-1:0] IX_DASN      = 6'd22;
    localparam logic [IDX_W-1:0] IX_EXC_SUM   = 6'd23;
    localparam logic [IDX_W-1:0] IX_EXC_MASK  = 6'd24;
    localparam logic [IDX_W-1:0] IX_INT_ID    = 6'd25;
    localparam logic [IDX_W-1:0] IX_MM_STAT   = 6'd26;
    localparam logic [IDX_W-1:0] IX_CYC       = 6'd27;
    localparam logic [IDX_W-1:0] IX_CYC_CTL   = 6'd28;
    localparam logic [IDX_W-1:0] IX_DINV_ALL  = 6'd29;
    localparam logic [IDX_W-1:0] IX_DINV_ASN  = 6'd30;
    localparam logic [IDX_W-1:0] IX_DINV_ONE  = 6'd31;
    localparam logic [IDX_W-1:0] IX_IINV_ALL  = 6'd32;
    localparam logic [IDX_W-1:0] IX_IINV_ASN  = 6'd33;
    localparam logic [IDX_W-1:0] IX_IINV_ONE  = 6'd34;
    localparam logic [IDX_W-1:0] IX_HWINT_CLR = 6'd35;

    function automatic rule_e rule_of(input logic [IDX_W-1:0] ix);
        rule_e r;
        if (ix <= IX_MISC) begin
            r = RULE_RW;
        end else begin
            unique case (ix)
                IX_EXC_ADDR, IX_AST_REQ, IX_AST_EN, IX_IPL, IX_CUR_MODE,
                IX_SWI_REQ, IX_ICTL, IX_PT_BASE, IX_CTEST, IX_CMODE,
                IX_IASN, IX_DASN:                         r = RULE_MASK;
                IX_EXC_SUM, IX_EXC_MASK:                  r = RULE_W2C;
                IX_INT_ID, IX_MM_STAT:                    r = RULE_RO;
                IX_ALT_MODE, IX_HWINT_CLR:                r = RULE_WO;
                IX_CYC:                                   r = RULE_CYC;
                IX_CYC_CTL:                               r = RULE_ONCE;
                IX_DINV_ALL, IX_DINV_ASN, IX_DINV_ONE,
                IX_IINV_ALL, IX_IINV_ASN, IX_IINV_ONE:    r = RULE_CMD;
                default:                                  r = RULE_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic [XLEN-1:0] mask_of(input logic [IDX_W-1:0] ix);
        logic [XLEN-1:0] m;
        unique case (ix)
            IX_EXC_ADDR:            m = ~64'h2;
            IX_AST_REQ, IX_AST_EN:  m = 64'hF;
            IX_IPL:                 m = 64'h1F;
            IX_CUR_MODE,
            IX_ALT_MODE:            m = 64'h18;
            IX_SWI_REQ:             m = 64'h7_FFF0;
            IX_ICTL:                m = 64'hFF_FFFF_0300;
            IX_PT_BASE:             m = 64'hFFFF_FFFF_C000_0000;
            IX_CTEST:               m = 64'h1FFB;
            IX_CMODE:               m = 64'h3F;
            IX_IASN:                m = 64'h7F0;
            IX_DASN:                m = 64'hFE00_0000_0000_0000;
            default:                m = '1;
        endcase
        return m;
    endfunction

    function automatic logic readable(input rule_e r);
        return (r == RULE_RW) || (r == RULE_MASK) || (r == RULE_W2C) ||
               (r == RULE_RO) || (r == RULE_CYC)  || (r == RULE_ONCE);
    endfunction

endpackage

// File: rtl/ctlreg_access.sv
module ctlreg_access
    import ctlreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             once_open,
    output logic             wr_commit,
    output logic             rd_ok,
    output logic             err,
    output inv_t             inv
);

    rule_e      wr_rule;
    rule_e      rd_rule;
    logic       bad_wr;
    logic       bad_rd;
    err_state_e err_q;
    err_state_e err_d;

    always_comb begin
        wr_rule = rule_of(wr_idx);
        rd_rule = rule_of(rd_idx);
        bad_wr  = wr_en && ((wr_rule == RULE_NONE) || (wr_rule == RULE_RO) ||
                            ((wr_rule == RULE_ONCE) && !once_open));
        bad_rd  = rd_en && !readable(rd_rule);
        wr_commit = wr_en && !bad_wr;
        rd_ok     = rd_en && !bad_rd;
    end

    // error tracker: next state
    always_comb begin
        err_d = err_q;
        unique case (err_q)
            ERR_CLEAR: if (bad_wr || bad_rd) err_d = ERR_HELD;
            ERR_HELD:  err_d = ERR_HELD;
            default:   err_d = ERR_CLEAR;
        endcase
    end

    // error tracker: state register
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= ERR_CLEAR;
        else        err_q <= err_d;
    end

    // outputs
    always_comb begin
        err       = (err_q == ERR_HELD);
        inv.d_all = wr_en && (wr_idx == IX_DINV_ALL);
        inv.d_asn = wr_en && (wr_idx == IX_DINV_ASN);
        inv.d_one = wr_en && (wr_idx == IX_DINV_ONE);
        inv.i_all = wr_en && (wr_idx == IX_IINV_ALL);
        inv.i_asn = wr_en && (wr_idx == IX_IINV_ASN);
        inv.i_one = wr_en && (wr_idx == IX_IINV_ONE);
    end

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    a_r9_err_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_rule == RULE_NONE)) |=> err);

    a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inv));

    a_r7_no_rd_ok_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rule == RULE_CMD) |-> !rd_ok);

endmodule

// File: rtl/ctlreg_cycle.sv
module ctlreg_cycle #(
    parameter int LIVE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_commit,
    output logic [LIVE_W-1:0] live_cnt,
    output logic              once_open
);
    import ctlreg_pkg::*;

    once_state_e once_q;
    once_state_e once_d;

    always_ff @(posedge clk) begin
        if (!rst_n) live_cnt <= '0;
        else        live_cnt <= live_cnt + LIVE_W'(1);
    end

    // counter-control guard: next state
    always_comb begin
        once_d = once_q;
        unique case (once_q)
            ONCE_OPEN:  if (ctl_commit) once_d = ONCE_SPENT;
            ONCE_SPENT: once_d = ONCE_SPENT;
            default:    once_d = ONCE_OPEN;
        endcase
    end

    // counter-control guard: state register
    always_ff @(posedge clk) begin
        if (!rst_n) once_q <= ONCE_OPEN;
        else        once_q <= once_d;
    end

    always_comb once_open = (once_q == ONCE_OPEN);

    a_r10_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (live_cnt == $past(live_cnt) + LIVE_W'(1)));

    a_r11_once_spent: assert property (@(posedge clk) disable iff (!rst_n)
        (once_q == ONCE_SPENT) |=> (once_q == ONCE_SPENT));

    a_r11_no_second: assert property (@(posedge clk) disable iff (!rst_n)
        (once_q == ONCE_SPENT) |-> !ctl_commit);

endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
    import ctlreg_pkg::*;
#(
    parameter logic [63:0] CODE_BASE_RST = 64'h8000,
    parameter int          CPU_ID_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CPU_ID_W-1:0] cpu_id,
    input  logic                wr_commit,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [XLEN-1:0]     wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [XLEN-1:0]     rd_word
);

    logic [XLEN-1:0] mem [NUM_DEF];
    logic [XLEN-1:0] nxt;
    rule_e           wr_rule;

    function automatic logic [XLEN-1:0] rst_val(input int i);
        logic [XLEN-1:0] v;
        v = '0;
        if (i == int'(IX_CODE_BASE))    v = CODE_BASE_RST;
        else if (i == int'(IX_MISC))    v = 64'h6;
        else if (i == int'(IX_SCR_CPU)) v = XLEN'(cpu_id);
        return v;
    endfunction

    always_comb begin
        wr_rule = rule_of(wr_idx);
        unique case (wr_rule)
            RULE_W2C, RULE_CMD: nxt = '0;
            RULE_ONCE:          nxt = 64'h1;
            default:            nxt = wr_data & mask_of(wr_idx);
        endcase
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_DEF; i++) begin
            if (!rst_n)
                mem[i] <= rst_val(i);
            else if (wr_commit && (wr_idx == IDX_W'(i)))
                mem[i] <= nxt;
        end
    end

    always_comb begin
        if (rd_idx < IDX_W'(NUM_DEF)) rd_word = mem[rd_idx];
        else                          rd_word = '0;
    end

    a_r6_no_illegal_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !((wr_rule == RULE_RO) || (wr_rule == RULE_NONE)));

    a_r5_sum_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && (wr_idx == IX_EXC_SUM)) |=> (mem[IX_EXC_SUM] == '0));

    a_r4_bit1_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && (wr_idx == IX_EXC_ADDR)) |=> (mem[IX_EXC_ADDR][1] == 1'b0));

    a_r3_ipl_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && (wr_idx == IX_IPL)) |=> (mem[IX_IPL][63:5] == '0));

    a_r6_ro_stable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mem[IX_INT_ID]));

endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
    import ctlreg_pkg::*;
#(
    parameter logic [63:0] CODE_BASE_RST = 64'h8000,
    parameter int          CPU_ID_W      = 8,
    parameter int          LIVE_W        = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CPU_ID_W-1:0] cpu_id,
    input  logic                wr_en,
    input  logic [5:0]          wr_idx,
    input  logic [63:0]         wr_data,
    input  logic                rd_en,
    input  logic [5:0]          rd_idx,
    output logic [63:0]         rd_data,
    output logic                err,
    output logic                xlat_d_all,
    output logic                xlat_d_asn,
    output logic                xlat_d_one,
    output logic                xlat_i_all,
    output logic                xlat_i_asn,
    output logic                xlat_i_one,
    output logic [63:0]         xlat_va
);

    logic              wr_commit;
    logic              rd_ok;
    logic              once_open;
    logic [LIVE_W-1:0] live_cnt;
    logic [XLEN-1:0]   rd_word;
    inv_t              inv;

    ctlreg_access u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .once_open (once_open),
        .wr_commit (wr_commit),
        .rd_ok     (rd_ok),
        .err       (err),
        .inv       (inv)
    );

    ctlreg_cycle #(.LIVE_W(LIVE_W)) u_cycle (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_commit (wr_commit && (wr_idx == IX_CYC_CTL)),
        .live_cnt   (live_cnt),
        .once_open  (once_open)
    );

    ctlreg_store #(
        .CODE_BASE_RST (CODE_BASE_RST),
        .CPU_ID_W      (CPU_ID_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_id    (cpu_id),
        .wr_commit (wr_commit),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_word   (rd_word)
    );

    always_comb begin
        if (!rd_ok)                rd_data = '0;
        else if (rd_idx == IX_CYC) rd_data = {rd_word[XLEN-1:LIVE_W], live_cnt};
        else                       rd_data = rd_word;
        xlat_d_all = inv.d_all;
        xlat_d_asn = inv.d_asn;
        xlat_d_one = inv.d_one;
        xlat_i_all = inv.i_all;
        xlat_i_asn = inv.i_asn;
        xlat_i_one = inv.i_one;
        xlat_va    = (inv.d_one || inv.i_one) ? wr_data : '0;
    end

    a_r7_illegal_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_ok) |-> (rd_data == '0));

    a_r12_va_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(xlat_d_one || xlat_i_one) |-> (xlat_va == '0));

endmodule

// File: tb/ctlreg_file_tb_top.sv
module ctlreg_file_tb_top;

    localparam logic [63:0] CB_RST = 64'h8000;
    localparam logic [7:0]  CPU    = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [5:0]  wr_idx, rd_idx;
    logic [63:0] wr_data, rd_data, xlat_va;
    logic        err;
    logic        xlat_d_all, xlat_d_asn, xlat_d_one, xlat_i_all, xlat_i_asn, xlat_i_one;
    logic [31:0] bc;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    ctlreg_file dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_id(CPU),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .err(err),
        .xlat_d_all(xlat_d_all), .xlat_d_asn(xlat_d_asn), .xlat_d_one(xlat_d_one),
        .xlat_i_all(xlat_i_all), .xlat_i_asn(xlat_i_asn), .xlat_i_one(xlat_i_one),
        .xlat_va(xlat_va)
    );

    // edges since reset release (R10 expectation)
    always @(posedge clk) begin
        if (!rst_n) bc <= 32'd0;
        else        bc <= bc + 32'd1;
    end

    // class codes: 0 undefined, 1 full, 2 masked, 3 clear-on-write,
    // 4 read-only, 5 write-only, 6 command, 7 cycle counter, 8 write-once
    function automatic int cls(input int ix);
        if (ix <= 9) return 1;
        if (ix >= 11 && ix <= 14) return 2;
        if (ix >= 16 && ix <= 22) return 2;
        case (ix)
            10: return 2;
            15, 35: return 5;
            23, 24: return 3;
            25, 26: return 4;
            27: return 7;
            28: return 8;
            29, 30, 31, 32, 33, 34: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic logic [63:0] msk(input int ix);
        case (ix)
            10: return ~64'h2;
            11, 12: return 64'hF;
            13: return 64'h1F;
            14: return 64'h18;
            16: return 64'h7FFF0;
            17: return 64'hFF_FFFF_0300;
            18: return 64'hFFFF_FFFF_C000_0000;
            19: return 64'h1FFB;
            20: return 64'h3F;
            21: return 64'h7F0;
            22: return 64'hFE00_0000_0000_0000;
            default: return '1;
        endcase
    endfunction

    function automatic logic [63:0] rstv(input int ix);
        if (ix == 7) return {56'd0, CPU};
        if (ix == 8) return CB_RST;
        if (ix == 9) return 64'h6;
        return 64'd0;
    endfunction

    function automatic bit rd_legal(input int ix);
        int c;
        c = cls(ix);
        return (c == 1) || (c == 2) || (c == 3) || (c == 4) || (c == 7) || (c == 8);
    endfunction

    function automatic bit wr_legal(input int ix);
        int c;
        c = cls(ix);
        return (c != 0) && (c != 4);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        wr_idx = '0; rd_idx = '0; wr_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input int ix, input logic [63:0] d);
        logic [5:0] ep;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(ix); wr_data = d;
        #2;
        ep = 6'd0;
        if (ix >= 29 && ix <= 34) ep[34 - ix] = 1'b1;
        chk("R12 pulses", {58'd0, xlat_d_all, xlat_d_asn, xlat_d_one,
                           xlat_i_all, xlat_i_asn, xlat_i_one}, {58'd0, ep});
        chk("R12 address", xlat_va, (ix == 31 || ix == 34) ? d : 64'd0);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int ix, output logic [63:0] d, output logic [31:0] snap);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = 6'(ix);
        #2;
        d = rd_data;
        snap = bc;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        logic [63:0] got, exp, pat;
        logic [31:0] snap;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        wr_idx = '0; rd_idx = '0; wr_data = '0;

        // R1: reset values of every readable index
        do_reset();
        for (int ix = 0; ix < 64; ix++) begin
            if (rd_legal(ix)) begin
                do_read(ix, got, snap);
                exp = (cls(ix) == 7) ? {32'd0, snap} : rstv(ix);
                chk($sformatf("R1 reset idx %0d", ix), got, exp);
            end
        end
        chk("R1 err after reset", {63'd0, err}, 64'd0);

        // R2-R8, R10, R11: per-index sweep with two patterns
        for (int p = 0; p < 2; p++) begin
            pat = (p == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h5A5A_C3C3_0F0F_9669;
            for (int ix = 0; ix < 64; ix++) begin
                do_reset();
                do_write(ix, pat);
                chk($sformatf("R6 R8 write err idx %0d", ix), {63'd0, err},
                    {63'd0, !wr_legal(ix)});
                do_read(ix, got, snap);
                case (cls(ix))
                    1: exp = pat;                          // R2
                    2: exp = pat & msk(ix);                // R3 R4
                    3: exp = 64'd0;                        // R5
                    4: exp = rstv(ix);                     // R6
                    7: exp = {pat[63:32], snap};           // R10
                    8: exp = 64'd1;                        // R11
                    default: exp = 64'd0;                  // R7 R8
                endcase
                chk($sformatf("R2-sweep data idx %0d", ix), got, exp);
                chk($sformatf("R7 R8 read err idx %0d", ix), {63'd0, err},
                    {63'd0, (!wr_legal(ix)) || (!rd_legal(ix))});
            end
        end

        // R9: sticky until reset
        do_reset();
        do_write(40, 64'h1);
        repeat (6) @(negedge clk);
        chk("R9 err held", {63'd0, err}, 64'd1);
        do_reset();
        @(negedge clk);
        chk("R9 err cleared by reset", {63'd0, err}, 64'd0);

        // R10: live low half advances with clock edges
        do_reset();
        repeat (37) @(negedge clk);
        do_read(27, got, snap);
        chk("R10 live count", got, {32'd0, snap});
        chk("R10 count value", {32'd0, snap}, 64'd38);

        // R11: write-once guard
        do_reset();
        do_write(28, 64'h0);
        chk("R11 first write legal", {63'd0, err}, 64'd0);
        do_write(28, 64'h0);
        chk("R11 second write err", {63'd0, err}, 64'd1);
        do_read(28, got, snap);
        chk("R11 stays 1", got, 64'd1);

        // R13: read returns old value in a same-index write cycle
        do_reset();
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd3; wr_data = 64'hDEAD_BEEF_0123_4567;
        rd_en = 1'b1; rd_idx = 6'd3;
        #2;
        chk("R13 old value", rd_data, 64'd0);
        @(negedge clk);
        wr_en = 1'b0;
        #2;
        chk("R13 new value", rd_data, 64'hDEAD_BEEF_0123_4567);
        @(negedge clk);
        rd_en = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule